// File: doc/BRIEF.md
# Fully Associative Translation Cache with Age-Ordered Replacement

This block translates virtual addresses to physical addresses for loads and stores. It has a small number of translation slots, four by default, and any virtual page can occupy any slot. A lookup carries a virtual address and a store flag. On a hit, the physical frame number replaces the page number. The page offset below the page boundary, which is 12 bits for 4 KB pages, passes through unchanged. The registered response appears one cycle after the request.

On a miss the block pulses a request to an external page-table walker and holds the pending page number. It then stays busy until the walker answers through the fill port. A present translation is installed. The block fills the lowest-numbered empty slot first. When every slot is in use, it replaces the least recently used slot.

The block keeps a dirty flag for each entry and sets it on a successful store. A store to a read-only page returns a write-protection fault, which lets copy-on-write be handled. A walker answer marked not present returns a page fault and is not cached. A flush input empties the whole cache in one cycle, for example on a context switch or an unmap.

Top module: `xlat_cache`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, every slot is empty, so any lookup misses.
- R2: A translated address is the entry's frame number concatenated with bits [11:0] of the request address. The low PAGE_BITS bits are never altered.
- R3: A lookup that hits raises `rsp_valid` in the cycle after the request, with no walker request and no busy period.
- R4: A lookup that misses pulses `walk_req` for exactly one cycle, with `walk_vpn` equal to the request's page number. `busy` stays high until `fill_valid` arrives. The response appears in the cycle after the fill.
- R5: While `busy` is high, lookups are not accepted. They produce no response and no walker request, and the dropped page stays uncached.
- R6: A present fill goes into the lowest empty slot. If no slot is empty, it goes into the least recently used slot. Every successful hit and every fill makes its slot the most recent.
- R7: A store that hits or fills a read-only entry responds with `rsp_valid=1` and `rsp_wprot=1`. The entry's dirty flag stays clear.
- R8: A fill with `fill_present=0` responds with `rsp_valid=1` and `rsp_absent=1`, and installs nothing. A repeat of the lookup misses again.
- R9: A store that hits a writable entry, or that fills a writable translation, sets that entry's dirty flag. `rsp_dirty` reports the entry's dirty flag as it stands after the access.
- R10: `flush` takes precedence over a lookup or an install in the same cycle. Such a lookup is dropped with no response and no walker request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all slots |
| req_valid | input | 1 | Lookup request |
| req_addr | input | VA_W | Virtual address of the lookup |
| req_store | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Response valid (registered) |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_wprot | output | 1 | Store to a read-only page |
| rsp_absent | output | 1 | Page not present |
| rsp_dirty | output | 1 | Dirty flag of the entry after the access |
| busy | output | 1 | Waiting for a walker answer |
| walk_req | output | 1 | One-cycle walker request pulse |
| walk_vpn | output | VA_W-PAGE_BITS | Page number to be walked |
| fill_valid | input | 1 | Walker answer valid |
| fill_pfn | input | PA_W-PAGE_BITS | Frame number from the walker |
| fill_present | input | 1 | Page is resident |
| fill_writable | input | 1 | Page may be written |

## Verification
The bench builds the block with four slots, a 32-bit virtual address and a 24-bit physical address. Because the page and frame numbers then differ in width (20 and 12 bits), a slip in the concatenation or the offset would show in the returned address. With four slots, five distinct pages are enough to force a replacement. The bench therefore fills the cache, touches the oldest entry, and installs a fifth page. It then probes each page at the ports to show which slot was evicted.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Control state of the lookup engine
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } xlat_state_e;
endpackage

// File: rtl/xlat_slots.sv
// Translation slot array: parallel tag compare, install port, dirty marking.
module xlat_slots #(
  parameter int SLOTS = 4,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [PFN_W-1:0] hit_pfn,
  output logic             hit_wr,
  output logic             hit_dirty,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PFN_W-1:0] ins_pfn,
  input  logic             ins_wr,
  input  logic             ins_dirty,
  input  logic             dirty_en,
  input  logic [IDX_W-1:0] dirty_idx,
  output logic             free_any,
  output logic [IDX_W-1:0] free_idx
);

  logic [SLOTS-1:0] val_q;
  logic [SLOTS-1:0] wr_q;
  logic [SLOTS-1:0] dty_q;
  logic [VPN_W-1:0] vpn_q [SLOTS];
  logic [PFN_W-1:0] pfn_q [SLOTS];
  logic [SLOTS-1:0] match;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign match[g] = val_q[g] && (vpn_q[g] == look_vpn);

    always_ff @(posedge clk) begin
      if (rst) begin
        val_q[g] <= 1'b0;
        wr_q[g]  <= 1'b0;
        dty_q[g] <= 1'b0;
        vpn_q[g] <= '0;
        pfn_q[g] <= '0;
      end else if (flush) begin
        val_q[g] <= 1'b0;
      end else if (ins_en && ins_idx == IDX_W'(g)) begin
        val_q[g] <= 1'b1;
        vpn_q[g] <= ins_vpn;
        pfn_q[g] <= ins_pfn;
        wr_q[g]  <= ins_wr;
        dty_q[g] <= ins_dirty;
      end else if (dirty_en && dirty_idx == IDX_W'(g)) begin
        dty_q[g] <= 1'b1;
      end
    end
  end

  // Encode the matching slot (at most one by construction of fills)
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit       = |match;
  assign hit_pfn   = pfn_q[hit_idx];
  assign hit_wr    = wr_q[hit_idx];
  assign hit_dirty = dty_q[hit_idx];

  // Lowest-numbered empty slot
  always_comb begin
    free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!val_q[i]) free_idx = IDX_W'(i);
    end
  end
  assign free_any = ~&val_q;

  // A page may sit in at most one slot (fills only follow misses)
  assert_single_match_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  // After a flush nothing can match
  assert_flush_empties_R1: assert property (@(posedge clk) disable iff (rst)
    flush |=> !hit);

endmodule

// File: rtl/xlat_lru.sv
// True LRU as an age ordering: age 0 = most recent, SLOTS-1 = victim.
module xlat_lru #(
  parameter int SLOTS = 4,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);

  logic [IDX_W-1:0] age_q [SLOTS];
  logic [IDX_W-1:0] touch_age;

  assign touch_age = age_q[touch_idx];

  for (genvar g = 0; g < SLOTS; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) begin
        age_q[g] <= IDX_W'(g);
      end else if (touch_en) begin
        if (touch_idx == IDX_W'(g))
          age_q[g] <= '0;
        else if (age_q[g] < touch_age)
          age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (age_q[i] == IDX_W'(SLOTS - 1)) victim_idx = IDX_W'(i);
    end
  end

  // Ages must stay a permutation
  for (genvar a = 0; a < SLOTS; a++) begin : g_chk_a
    for (genvar b = a + 1; b < SLOTS; b++) begin : g_chk_b
      assert_ages_distinct_R6: assert property (@(posedge clk) disable iff (rst)
        age_q[a] != age_q[b]);
    end
  end

  // A touched slot becomes the most recent one
  assert_touch_newest_R6: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> age_q[$past(touch_idx)] == '0);

endmodule

// File: rtl/xlat_cache.sv
// Fully associative translation cache, top level.
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SLOTS     = 4,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PFN_W = PA_W - PAGE_BITS,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_addr,
  input  logic             req_store,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_wprot,
  output logic             rsp_absent,
  output logic             rsp_dirty,
  output logic             busy,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             fill_valid,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_present,
  input  logic             fill_writable
);

  xlat_state_e state_q;
  logic [VPN_W-1:0]     pend_vpn_q;
  logic [PAGE_BITS-1:0] pend_off_q;
  logic                 pend_store_q;

  logic [VPN_W-1:0]     req_vpn;
  logic [PAGE_BITS-1:0] req_off;
  assign req_vpn = req_addr[VA_W-1:PAGE_BITS];
  assign req_off = req_addr[PAGE_BITS-1:0];

  logic             s_hit, s_wr, s_dirty, s_free_any;
  logic [IDX_W-1:0] s_hit_idx, s_free_idx, victim_idx;
  logic [PFN_W-1:0] s_pfn;

  logic accept, hit_ok, hit_wp, mark_dirty, miss;
  logic fill_take, install, fill_wp, ins_dirty, touch_en;
  logic [IDX_W-1:0] ins_idx, touch_idx;

  assign accept     = (state_q == ST_IDLE) && req_valid && !flush;
  assign hit_ok     = accept && s_hit;
  assign miss       = accept && !s_hit;
  assign hit_wp     = hit_ok && req_store && !s_wr;
  assign mark_dirty = hit_ok && req_store && s_wr;

  assign fill_take  = (state_q == ST_WAIT) && fill_valid;
  assign install    = fill_take && fill_present && !flush;
  assign fill_wp    = pend_store_q && !fill_writable;
  assign ins_dirty  = pend_store_q && fill_writable;
  assign ins_idx    = s_free_any ? s_free_idx : victim_idx;

  assign touch_en   = install || (hit_ok && !hit_wp);
  assign touch_idx  = install ? ins_idx : s_hit_idx;

  xlat_slots #(.SLOTS(SLOTS), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .look_vpn  (req_vpn),
    .hit       (s_hit),
    .hit_idx   (s_hit_idx),
    .hit_pfn   (s_pfn),
    .hit_wr    (s_wr),
    .hit_dirty (s_dirty),
    .ins_en    (install),
    .ins_idx   (ins_idx),
    .ins_vpn   (pend_vpn_q),
    .ins_pfn   (fill_pfn),
    .ins_wr    (fill_writable),
    .ins_dirty (ins_dirty),
    .dirty_en  (mark_dirty),
    .dirty_idx (s_hit_idx),
    .free_any  (s_free_any),
    .free_idx  (s_free_idx)
  );

  xlat_lru #(.SLOTS(SLOTS)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );

  // Control and pending request
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      pend_vpn_q   <= '0;
      pend_off_q   <= '0;
      pend_store_q <= 1'b0;
    end else begin
      if (miss) begin
        state_q      <= ST_WAIT;
        pend_vpn_q   <= req_vpn;
        pend_off_q   <= req_off;
        pend_store_q <= req_store;
      end else if (fill_take) begin
        state_q <= ST_IDLE;
      end
    end
  end

  // Registered response and walker outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_wprot  <= 1'b0;
      rsp_absent <= 1'b0;
      rsp_dirty  <= 1'b0;
      walk_req   <= 1'b0;
    end else begin
      rsp_valid  <= hit_ok || fill_take;
      rsp_wprot  <= hit_wp || (fill_take && fill_present && fill_wp);
      rsp_absent <= fill_take && !fill_present;
      walk_req   <= miss;
      if (hit_ok) begin
        rsp_paddr <= {s_pfn, req_off};
        rsp_dirty <= s_dirty || mark_dirty;
      end else if (fill_take) begin
        rsp_paddr <= {fill_pfn, pend_off_q};
        rsp_dirty <= fill_present && ins_dirty;
      end
    end
  end

  assign busy     = (state_q == ST_WAIT);
  assign walk_vpn = pend_vpn_q;

  assert_hit_next_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE) && req_valid && !flush && s_hit) |=> rsp_valid && !busy && !walk_req);

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    hit_ok |=> rsp_paddr[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0]));

  assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid && !fill_valid) |=> !rsp_valid && !walk_req && busy);

  assert_absent_fault_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && fill_valid && !fill_present) |=> rsp_absent && rsp_valid && !rsp_wprot && !busy);

  assert_wprot_clean_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_wprot |-> rsp_valid && !rsp_dirty);

  assert_flush_drops_R10: assert property (@(posedge clk) disable iff (rst)
    (flush && !busy) |=> !rsp_valid && !walk_req);

endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int VA_W = 32;
  localparam int PA_W = 24;
  localparam int PB   = 12;
  localparam int VPN_W = VA_W - PB;
  localparam int PFN_W = PA_W - PB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_addr = '0;
  logic req_store = 1'b0;
  logic rsp_valid;
  logic [PA_W-1:0] rsp_paddr;
  logic rsp_wprot, rsp_absent, rsp_dirty, busy, walk_req;
  logic [VPN_W-1:0] walk_vpn;
  logic fill_valid = 1'b0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic fill_present = 1'b0;
  logic fill_writable = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xlat_cache #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PB), .SLOTS(4)) u_xlat_cache (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_addr(req_addr), .req_store(req_store),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_wprot(rsp_wprot),
    .rsp_absent(rsp_absent), .rsp_dirty(rsp_dirty), .busy(busy),
    .walk_req(walk_req), .walk_vpn(walk_vpn),
    .fill_valid(fill_valid), .fill_pfn(fill_pfn),
    .fill_present(fill_present), .fill_writable(fill_writable)
  );

  function automatic logic [PFN_W-1:0] pfn_of(input logic [VPN_W-1:0] v);
    return v[PFN_W-1:0] ^ 12'hA5C;
  endfunction

  function automatic logic [PA_W-1:0] pa_of(input logic [VA_W-1:0] a);
    return {pfn_of(a[VA_W-1:PB]), a[PB-1:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [VA_W-1:0] a, input bit st);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_store = st;
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0;
  endtask

  task automatic fill(input logic [PFN_W-1:0] p, input bit wr, input bit pres);
    @(negedge clk);
    fill_valid = 1'b1; fill_pfn = p; fill_writable = wr; fill_present = pres;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic expect_hit(input logic [VA_W-1:0] a, input bit st, input string tag);
    lookup(a, st);
    chk(rsp_valid == 1'b1, {tag, " hit rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk(walk_req == 1'b0 && busy == 1'b0, {tag, " hit no walk"}, 64'({walk_req, busy}), 64'd0);
    chk(rsp_paddr == pa_of(a), {tag, " hit paddr"}, 64'(rsp_paddr), 64'(pa_of(a)));
  endtask

  task automatic expect_miss(input logic [VA_W-1:0] a, input bit st, input string tag);
    lookup(a, st);
    chk(walk_req == 1'b1 && busy == 1'b1 && rsp_valid == 1'b0, {tag, " miss walk/busy"},
        64'({walk_req, busy, rsp_valid}), 64'b110);
    chk(walk_vpn == a[VA_W-1:PB], {tag, " walk_vpn"}, 64'(walk_vpn), 64'(a[VA_W-1:PB]));
  endtask

  task automatic miss_fill(input logic [VA_W-1:0] a, input bit st, input bit wr, input string tag);
    expect_miss(a, st, tag);
    fill(pfn_of(a[VA_W-1:PB]), wr, 1'b1);
    chk(rsp_valid == 1'b1 && busy == 1'b0, {tag, " fill response"}, 64'({rsp_valid, busy}), 64'b10);
    chk(rsp_paddr == pa_of(a), {tag, " fill paddr"}, 64'(rsp_paddr), 64'(pa_of(a)));
  endtask

  // R1 R2 R3 R4: reset state, first miss, then hit
  task automatic t_reset_basic();
    chk(rsp_valid == 1'b0 && busy == 1'b0 && walk_req == 1'b0, "R1 reset outputs",
        64'({rsp_valid, busy, walk_req}), 64'd0);
    expect_miss(32'h0001_2345, 1'b0, "R1");
    @(negedge clk);
    chk(walk_req == 1'b0 && busy == 1'b1, "R4 walk pulse one cycle, busy held",
        64'({walk_req, busy}), 64'b01);
    fill(pfn_of(20'h00012), 1'b1, 1'b1);
    chk(rsp_valid == 1'b1 && busy == 1'b0, "R4 response after fill", 64'({rsp_valid, busy}), 64'b10);
    chk(rsp_paddr == pa_of(32'h0001_2345), "R2 fill paddr", 64'(rsp_paddr), 64'(pa_of(32'h0001_2345)));
    expect_hit(32'h0001_2FF7, 1'b0, "R3 R2");
  endtask

  // R5: lookups while busy are dropped
  task automatic t_busy();
    do_flush();
    expect_miss(32'h0008_0010, 1'b0, "R5 setup");
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0009_0020;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b0 && walk_req == 1'b0 && busy == 1'b1, "R5 busy ignores lookup",
        64'({rsp_valid, walk_req, busy}), 64'b001);
    chk(walk_vpn == 20'h00080, "R5 pending page kept", 64'(walk_vpn), 64'h80);
    fill(pfn_of(20'h00080), 1'b1, 1'b1);
    chk(rsp_paddr == pa_of(32'h0008_0010), "R5 original completes", 64'(rsp_paddr), 64'(pa_of(32'h0008_0010)));
    expect_miss(32'h0009_0020, 1'b0, "R5 dropped page uncached");
    fill(pfn_of(20'h00090), 1'b1, 1'b1);
  endtask

  // R7: store to read-only pages
  task automatic t_wprot();
    do_flush();
    miss_fill(32'h0003_0000, 1'b0, 1'b0, "R7 setup");
    lookup(32'h0003_0004, 1'b1);
    chk(rsp_valid == 1'b1 && rsp_wprot == 1'b1 && rsp_dirty == 1'b0, "R7 store hit read-only",
        64'({rsp_valid, rsp_wprot, rsp_dirty}), 64'b110);
    lookup(32'h0003_0008, 1'b0);
    chk(rsp_valid == 1'b1 && rsp_wprot == 1'b0 && rsp_dirty == 1'b0, "R7 entry stays clean",
        64'({rsp_valid, rsp_wprot, rsp_dirty}), 64'b100);
    expect_miss(32'h0004_0000, 1'b1, "R7 store miss");
    fill(pfn_of(20'h00040), 1'b0, 1'b1);
    chk(rsp_valid == 1'b1 && rsp_wprot == 1'b1 && rsp_dirty == 1'b0, "R7 store fill read-only",
        64'({rsp_valid, rsp_wprot, rsp_dirty}), 64'b110);
  endtask

  // R8: not-present answers
  task automatic t_absent();
    do_flush();
    expect_miss(32'h0007_0000, 1'b0, "R8 first");
    fill(12'h000, 1'b1, 1'b0);
    chk(rsp_valid == 1'b1 && rsp_absent == 1'b1 && busy == 1'b0, "R8 absent fault",
        64'({rsp_valid, rsp_absent, busy}), 64'b110);
    expect_miss(32'h0007_0000, 1'b0, "R8 not installed");
    fill(pfn_of(20'h00070), 1'b1, 1'b1);
    chk(rsp_absent == 1'b0, "R8 present clears fault", 64'(rsp_absent), 64'd0);
  endtask

  // R9: dirty marking
  task automatic t_dirty();
    do_flush();
    miss_fill(32'h0005_0000, 1'b0, 1'b1, "R9 setup");
    chk(rsp_dirty == 1'b0, "R9 load fill clean", 64'(rsp_dirty), 64'd0);
    lookup(32'h0005_0010, 1'b0);
    chk(rsp_dirty == 1'b0, "R9 load hit clean", 64'(rsp_dirty), 64'd0);
    lookup(32'h0005_0020, 1'b1);
    chk(rsp_dirty == 1'b1 && rsp_wprot == 1'b0, "R9 store hit dirties",
        64'({rsp_dirty, rsp_wprot}), 64'b10);
    lookup(32'h0005_0030, 1'b0);
    chk(rsp_dirty == 1'b1, "R9 dirty persists", 64'(rsp_dirty), 64'd1);
    expect_miss(32'h0006_0000, 1'b1, "R9 store miss");
    fill(pfn_of(20'h00060), 1'b1, 1'b1);
    chk(rsp_dirty == 1'b1, "R9 store fill dirty", 64'(rsp_dirty), 64'd1);
  endtask

  // R1 R10: flush behaviour
  task automatic t_flush();
    do_flush();
    miss_fill(32'h000A_0000, 1'b0, 1'b1, "R1 setup");
    expect_hit(32'h000A_0100, 1'b0, "R1 before flush");
    do_flush();
    expect_miss(32'h000A_0100, 1'b0, "R1 after flush");
    fill(pfn_of(20'h000A0), 1'b1, 1'b1);
    @(negedge clk);
    flush = 1'b1; req_valid = 1'b1; req_addr = 32'h000A_0200;
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    chk(rsp_valid == 1'b0 && walk_req == 1'b0 && busy == 1'b0, "R10 lookup dropped by flush",
        64'({rsp_valid, walk_req, busy}), 64'd0);
    expect_miss(32'h000A_0200, 1'b0, "R10 flush took effect");
    fill(pfn_of(20'h000A0), 1'b1, 1'b1);
  endtask

  // R6: empty slots first, then least recently used
  task automatic t_lru();
    do_flush();
    for (int v = 16; v < 20; v++) miss_fill(32'(v) << PB, 1'b0, 1'b1, "R6 fill");
    expect_hit(32'h0001_0000, 1'b0, "R6 touch oldest");
    miss_fill(32'h0002_0000, 1'b0, 1'b1, "R6 fifth page");
    expect_miss(32'h0001_1000, 1'b0, "R6 LRU victim evicted");
    fill(12'h000, 1'b1, 1'b0);
    expect_hit(32'h0001_0004, 1'b0, "R6 recent kept");
    expect_hit(32'h0001_2004, 1'b0, "R6 kept");
    expect_hit(32'h0001_3004, 1'b0, "R6 kept");
    expect_hit(32'h0002_0004, 1'b0, "R6 new page");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_basic();
    t_busy();
    t_wprot();
    t_absent();
    t_dirty();
    t_flush();
    t_lru();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule